// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. A fast system clock samples four asynchronous pins: an active-low frame select, a serial clock, serial data and an active-low load strobe. Each pin passes through a two-flop synchronizer. Edges are then found in the system clock domain, which must run at least four times faster than the serial clock. While the frame select is low, each rising serial-clock edge shifts one data bit into an input shift register, most significant bit first.

A word reaches the parallel converter code in one of two ways, picked by a transfer-mode input. In the first mode, the word moves across when the frame select rises. In the second mode, the rising frame select only marks the word as ready, and a later falling edge on the load strobe moves it across. A frame that ends with a bit count other than 16 leaves the code unchanged and raises a frame-error flag. Reset clears the code to zero. In bipolar use that code means negative full scale. For bipolar use the block also registers a bipolar flag and presents the code converted to two's complement.

Top module: `serial_dac_front`

## Requirements
- R1: After reset, `code_o` is 0x0000, `twos_o` is 0x0000, `frame_err_o` is 0 and `bipolar_o` is 0.
- R2: In transfer mode 0 (`xfer_mode_i`=0), a frame of exactly 16 rising serial-clock edges with `cs_n_i` low loads the bits into `code_o` when `cs_n_i` rises. The first bit becomes bit 15 and the last becomes bit 0.
- R3: A frame that ends with fewer than 16 bits leaves `code_o` unchanged and sets `frame_err_o` to 1.
- R4: A frame that ends with more than 16 bits leaves `code_o` unchanged and sets `frame_err_o` to 1.
- R5: A frame that ends with exactly 16 bits clears `frame_err_o` to 0.
- R6: Serial-clock edges while `cs_n_i` is high neither shift data nor count bits.
- R7: In transfer mode 1, the rise of `cs_n_i` leaves `code_o` unchanged. A later falling edge of `load_n_i` while `cs_n_i` is high loads the last complete word.
- R8: A falling edge of `load_n_i` while `cs_n_i` is low has no effect on `code_o`.
- R9: In transfer mode 1, a load-strobe fall after a frame of the wrong length does not load, and neither does one after a new frame has started.
- R10: `bipolar_o` is `bipolar_i` registered once. While it is 1, `twos_o` equals `code_o` with bit 15 inverted (0x8000 maps to 0x0000, 0xFFFF to 0x7FFF, 0x0000 to 0x8000). While it is 0, `twos_o` equals `code_o`.
- R11: Counting from the system-clock rising edge that first samples a changed pin, that change acts on the outputs at the third such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low frame select (asynchronous) |
| sck_i | input | 1 | Serial clock; data sampled on its rising edge (asynchronous) |
| sdi_i | input | 1 | Serial data, MSB first (asynchronous) |
| load_n_i | input | 1 | Active-low load strobe; falling edge transfers in mode 1 (asynchronous) |
| xfer_mode_i | input | 1 | 0: transfer on frame-select rise; 1: transfer on load-strobe fall |
| bipolar_i | input | 1 | Selects offset-binary bipolar interpretation |
| code_o | output | 16 | Parallel converter code |
| twos_o | output | 16 | Code in two's complement when bipolar, else equal to `code_o` |
| bipolar_o | output | 1 | Registered bipolar flag |
| frame_err_o | output | 1 | Last frame ended with a bit count other than 16 |

## Verification
The words 0xA5C3 and 0x0001 show bit order and placement, and 0x1234 after a short frame shows that the error flag clears. Frames of 8, 5 and 17 bits separate the short-count and long-count paths from a correct count of 16. In mode 1, strobes are placed at four points: after a good frame, in the middle of a frame, after stray serial-clock edges while the frame select is high, and after a bad frame. Together they separate a real transfer from an ignored edge. The bipolar codes 0x8000, 0xFFFF and 0x0000 test the sign conversion at its midpoint and at both ends. A timed frame end fixes the three-edge latency. A per-cycle model built from sampled pin histories checks that latency on every clock.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

  // Position of each asynchronous pin in the synchronizer vector
  localparam int PIN_CS   = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_SDI  = 2;
  localparam int PIN_LOAD = 3;
  localparam int N_PINS   = 4;

  // Idle levels: select and strobe rest high, clock and data low
  localparam logic [N_PINS-1:0] PIN_IDLE = 4'b1001;

  typedef enum logic {
    XFER_ON_SELECT = 1'b0,
    XFER_ON_STROBE = 1'b1
  } xfer_mode_e;

endpackage

// File: rtl/dfe_sync.sv
module dfe_sync #(
  parameter int          N       = 4,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/dfe_edges.sv
module dfe_edges #(
  parameter int           N       = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_edge
    logic prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL[i];
      else        prev <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev;
    assign fall[i] = ~lvl[i] & prev;
  end

endmodule

// File: rtl/dfe_shifter.sv
module dfe_shifter #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          shift_en,
  input  logic          din,
  output logic [W-1:0]  word,
  output logic [CW-1:0] bit_cnt,
  output logic          full
);

  localparam logic [CW-1:0] CNT_FULL = CW'(W);
  localparam logic [CW-1:0] CNT_OVER = CW'(W + 1);

  // Saturating count: any value above W is reported as W+1
  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c);
    return (c >= CNT_OVER) ? CNT_OVER : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (frame_start) begin
      bit_cnt <= '0;
    end else if (shift_en) begin
      word    <= {word[W-2:0], din};
      bit_cnt <= cnt_next(bit_cnt);
    end
  end

  assign full = (bit_cnt == CNT_FULL);

endmodule

// File: rtl/dfe_latch_ctl.sv
module dfe_latch_ctl
  import dfe_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  xfer_mode_e   mode,
  input  logic         bipolar_in,
  input  logic         frame_start,
  input  logic         frame_end,
  input  logic         len_ok,
  input  logic         strobe_fall,
  input  logic         sel_high,
  input  logic [W-1:0] word,
  output logic [W-1:0] code,
  output logic [W-1:0] twos,
  output logic         bip,
  output logic         err,
  output logic         ready
);

  // Offset binary to two's complement: flip the sign bit
  function automatic logic [W-1:0] offset_to_twos(input logic [W-1:0] c);
    return {~c[W-1], c[W-2:0]};
  endfunction

  logic load_on_select;
  logic load_on_strobe;

  assign load_on_select = frame_end & len_ok & (mode == XFER_ON_SELECT);
  assign load_on_strobe = strobe_fall & sel_high & ready & (mode == XFER_ON_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      err   <= 1'b0;
      ready <= 1'b0;
      bip   <= 1'b0;
    end else begin
      bip <= bipolar_in;
      if (frame_start) ready <= 1'b0;
      if (frame_end) begin
        if (len_ok) begin
          err   <= 1'b0;
          ready <= (mode == XFER_ON_STROBE);
        end else begin
          err   <= 1'b1;
          ready <= 1'b0;
        end
      end
      if (load_on_select || load_on_strobe) code <= word;
    end
  end

  assign twos = bip ? offset_to_twos(code) : code;

endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
  import dfe_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n_i,
  input  logic         sck_i,
  input  logic         sdi_i,
  input  logic         load_n_i,
  input  logic         xfer_mode_i,
  input  logic         bipolar_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] twos_o,
  output logic         bipolar_o,
  output logic         frame_err_o
);

  localparam int CW = $clog2(W + 2);

  logic [N_PINS-1:0] pins_raw, pins_lvl, pins_rise, pins_fall;

  assign pins_raw[PIN_CS]   = cs_n_i;
  assign pins_raw[PIN_SCK]  = sck_i;
  assign pins_raw[PIN_SDI]  = sdi_i;
  assign pins_raw[PIN_LOAD] = load_n_i;

  dfe_sync #(.N(N_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_lvl)
  );

  dfe_edges #(.N(N_PINS), .RST_VAL(PIN_IDLE)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl(pins_lvl), .rise(pins_rise), .fall(pins_fall)
  );

  // Named internal events
  logic ev_sel_fall, ev_sel_rise, ev_sck_rise, ev_load_fall, sel_low, data_bit;
  assign ev_sel_fall  = pins_fall[PIN_CS];
  assign ev_sel_rise  = pins_rise[PIN_CS];
  assign ev_sck_rise  = pins_rise[PIN_SCK];
  assign ev_load_fall = pins_fall[PIN_LOAD];
  assign sel_low      = ~pins_lvl[PIN_CS];
  assign data_bit     = pins_lvl[PIN_SDI];

  logic unused_edges;
  assign unused_edges = ^{pins_lvl[PIN_SCK], pins_lvl[PIN_LOAD], pins_rise[PIN_SDI],
                          pins_fall[PIN_SDI], pins_fall[PIN_SCK], pins_rise[PIN_LOAD]};

  logic          shift_en;
  logic [W-1:0]  shift_word;
  logic [CW-1:0] bit_cnt;
  logic          word_full;
  logic          word_ready;

  assign shift_en = ev_sck_rise & sel_low & ~ev_sel_fall;

  dfe_shifter #(.W(W), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .frame_start(ev_sel_fall), .shift_en(shift_en),
    .din(data_bit), .word(shift_word), .bit_cnt(bit_cnt), .full(word_full)
  );

  xfer_mode_e mode;
  assign mode = xfer_mode_e'(xfer_mode_i);

  dfe_latch_ctl #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bipolar_in(bipolar_i),
    .frame_start(ev_sel_fall), .frame_end(ev_sel_rise), .len_ok(word_full),
    .strobe_fall(ev_load_fall), .sel_high(~sel_low), .word(shift_word),
    .code(code_o), .twos(twos_o), .bip(bipolar_o), .err(frame_err_o),
    .ready(word_ready)
  );

endmodule

// File: rtl/dfe_checker.sv
module dfe_checker #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_sel_rise,
  input logic          ev_sck_rise,
  input logic          ev_load_fall,
  input logic          sel_low,
  input logic          mode,
  input logic [CW-1:0] bit_cnt,
  input logic [W-1:0]  shift_word,
  input logic [W-1:0]  code,
  input logic [W-1:0]  twos,
  input logic          bip,
  input logic          err
);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (code == '0) && !err);

  a_r2_select_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel_rise && (bit_cnt == CW'(W)) && !mode |=> code == $past(shift_word));

  a_r3_bad_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel_rise && (bit_cnt != CW'(W)) |=> $stable(code) && err);

  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(W + 1));

  a_r5_good_len_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel_rise && (bit_cnt == CW'(W)) |=> !err);

  a_r6_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sck_rise && !sel_low |=> $stable(shift_word) && $stable(bit_cnt));

  a_r7_no_select_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    mode && ev_sel_rise |=> $stable(code));

  a_r8_strobe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_fall && sel_low |=> $stable(code));

  a_r10_sign_flip: assert property (@(posedge clk) disable iff (!rst_n)
    bip |-> (twos[W-1] != code[W-1]) && (twos[W-2:0] == code[W-2:0]));

  a_r10_unipolar_same: assert property (@(posedge clk) disable iff (!rst_n)
    !bip |-> twos == code);

endmodule

bind serial_dac_front dfe_checker #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_sel_rise(ev_sel_rise), .ev_sck_rise(ev_sck_rise),
  .ev_load_fall(ev_load_fall), .sel_low(sel_low), .mode(xfer_mode_i),
  .bit_cnt(bit_cnt), .shift_word(shift_word), .code(code_o), .twos(twos_o),
  .bip(bipolar_o), .err(frame_err_o)
);

// File: tb/serial_dac_front_bench.sv
module serial_dac_front_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, load_n = 1'b1;
  logic mode = 1'b0, bipolar = 1'b0;
  logic [15:0] code, twos;
  logic bip_o, err_o;

  int total = 0, failed = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_dac_front u_serial_dac_front (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .load_n_i(load_n), .xfer_mode_i(mode), .bipolar_i(bipolar),
    .code_o(code), .twos_o(twos), .bipolar_o(bip_o), .frame_err_o(err_o)
  );

  // Behavioural model: pin histories sampled at each edge, newest in bit 0
  bit [2:0] hc, hk, hd, hl;
  int m_cnt;
  logic [15:0] m_sh, m_code;
  bit m_err, m_rdy, m_bip;

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = 3'b111; hk = 3'b000; hd = 3'b000; hl = 3'b111;
      m_cnt = 0; m_sh = 16'h0; m_code = 16'h0; m_err = 0; m_rdy = 0; m_bip = 0;
    end else begin
      bit sel_fall, sel_rise, k_rise, l_fall;
      sel_fall = !hc[1] && hc[2];
      sel_rise = hc[1] && !hc[2];
      k_rise   = hk[1] && !hk[2];
      l_fall   = !hl[1] && hl[2];
      if (l_fall && hc[1] && m_rdy && mode) m_code = m_sh;
      if (sel_fall) begin
        m_cnt = 0; m_rdy = 0;
      end else if (k_rise && !hc[1]) begin
        m_sh = {m_sh[14:0], hd[1]};
        if (m_cnt < 17) m_cnt++;
      end
      if (sel_rise) begin
        if (m_cnt == 16) begin
          m_err = 0;
          if (!mode) m_code = m_sh; else m_rdy = 1;
        end else begin
          m_err = 1; m_rdy = 0;
        end
      end
      m_bip = bipolar;
      hc = {hc[1:0], cs_n}; hk = {hk[1:0], sck};
      hd = {hd[1:0], sdi};  hl = {hl[1:0], load_n};
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R11 latency included)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11 cycle code", {16'h0, code}, {16'h0, m_code});
      check("R11 cycle err", {31'h0, err_o}, {31'h0, m_err});
      check("R10 cycle twos", {16'h0, twos}, {16'h0, (m_bip ? (m_code ^ 16'h8000) : m_code)});
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_frame();
    cs_n = 1'b0; wait_clk(4);
  endtask

  task automatic send_bits(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i]; sck = 1'b0; wait_clk(4);
      sck = 1'b1; wait_clk(4);
    end
    sck = 1'b0;
  endtask

  task automatic end_frame();
    sck = 1'b0; wait_clk(4);
    cs_n = 1'b1; wait_clk(8);
  endtask

  task automatic frame(logic [31:0] w, int n);
    start_frame(); send_bits(w, n); end_frame();
  endtask

  task automatic strobe();
    load_n = 1'b0; wait_clk(4);
    load_n = 1'b1; wait_clk(8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    check("R1 reset code", {16'h0, code}, 32'h0);
    check("R1 reset twos", {16'h0, twos}, 32'h0);
    check("R1 reset err", {31'h0, err_o}, 32'h0);
    check("R1 reset bipolar", {31'h0, bip_o}, 32'h0);
    rst_n = 1'b1; wait_clk(4);

    frame(32'hA5C3, 16);
    check("R2 word A5C3", {16'h0, code}, 32'hA5C3);
    frame(32'h0001, 16);
    check("R2 MSB first 0001", {16'h0, code}, 32'h0001);

    frame(32'hFF, 8);
    check("R3 short frame hold", {16'h0, code}, 32'h0001);
    check("R3 short frame err", {31'h0, err_o}, 32'h1);

    frame(32'h1234, 16);
    check("R5 err cleared", {31'h0, err_o}, 32'h0);
    check("R5 word 1234", {16'h0, code}, 32'h1234);

    frame(32'h1FFFF, 17);
    check("R4 long frame hold", {16'h0, code}, 32'h1234);
    check("R4 long frame err", {31'h0, err_o}, 32'h1);

    // R11: frame-select rise acts at the third sampling edge
    start_frame(); send_bits(32'h0F0F, 16); sck = 1'b0; wait_clk(4);
    cs_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11 before third edge", {16'h0, code}, 32'h1234);
    @(negedge clk);
    check("R11 at third edge", {16'h0, code}, 32'h0F0F);
    wait_clk(8);

    bipolar = 1'b1;
    frame(32'h8000, 16);
    check("R10 bipolar flag", {31'h0, bip_o}, 32'h1);
    check("R10 8000 to 0000", {16'h0, twos}, 32'h0000);
    frame(32'hFFFF, 16);
    check("R10 FFFF to 7FFF", {16'h0, twos}, 32'h7FFF);
    frame(32'h0000, 16);
    check("R10 0000 to 8000", {16'h0, twos}, 32'h8000);
    bipolar = 1'b0; wait_clk(4);
    check("R10 unipolar twos", {16'h0, twos}, {16'h0, code});

    mode = 1'b1; wait_clk(4);
    frame(32'hBEEF, 16);
    check("R7 no transfer on select", {16'h0, code}, 32'h0000);
    strobe();
    check("R7 strobe loads BEEF", {16'h0, code}, 32'hBEEF);

    start_frame(); send_bits(32'h43, 8);
    strobe();
    check("R8 strobe in frame ignored", {16'h0, code}, 32'hBEEF);
    send_bits(32'h21, 8); end_frame();
    check("R8 still BEEF", {16'h0, code}, 32'hBEEF);
    strobe();
    check("R7 strobe loads 4321", {16'h0, code}, 32'h4321);

    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sck = 1'b1; wait_clk(4); sck = 1'b0; wait_clk(4);
    end
    strobe();
    check("R6 idle clocks ignored", {16'h0, code}, 32'h4321);

    frame(32'h1F, 5);
    strobe();
    check("R9 bad frame no load", {16'h0, code}, 32'h4321);
    check("R9 err set", {31'h0, err_o}, 32'h1);

    frame(32'h5A5A, 16);
    start_frame(); send_bits(32'h3, 2); cs_n = 1'b1; wait_clk(8);
    strobe();
    check("R9 restarted frame no load", {16'h0, code}, 32'h4321);

    mode = 1'b0; wait_clk(4);
    frame(32'hC001, 16);
    check("R2 back to select mode", {16'h0, code}, 32'hC001);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule